// File: doc/BRIEF.md
# Punctured 16QAM Symbol Mapper with Independent I/Q Axes

This block sits after a rate-1/3 parallel turbo encoder. Each cycle that a handshake completes it accepts one systematic bit together with the two parity bits produced for that same bit position. It punctures the parity down to rate 1/2. From the first bit of each pair it keeps the first-encoder parity, and from the second bit it keeps the second-encoder parity. Every two accepted bit positions become one 16QAM symbol.

The symbol is formed as two independent 4-level amplitude signals. The in-phase axis carries the first systematic bit with its kept parity. The quadrature axis carries the second systematic bit with its kept parity. The output is a pair of signed amplitude codes with a single-cycle valid strobe. A mode input selects whether the systematic bit or the parity bit occupies the protected sign position on each axis.

Top module: `qam16_iq_mapper`

## Requirements
- R1: After a synchronous reset, out_valid is 0, in_ready is 1 and the next accepted bit is treated as the first (odd) bit of a pair.
- R2: For the first bit of a pair, in_d and in_p are kept and in_q is discarded; in_q of that bit has no effect on any output.
- R3: For the second bit of a pair, in_d and in_q are kept and in_p is discarded; in_p of that bit has no effect on any output.
- R4: out_valid is high for exactly one cycle, in the cycle after the second bit of a pair is accepted, and is low in every other cycle.
- R5: in_ready is low in each cycle in which out_valid is high and high in all other cycles; a bit offered while in_ready is low is not taken.
- R6: Each axis maps its bit pair (first, second) to a 3-bit two's-complement level: 01 gives -3 (3'b101), 00 gives -1 (3'b111), 10 gives +1 (3'b001), 11 gives +3 (3'b011). The first bit is the sign and the protected position.
- R7: With swap_mode at 0, the I pair is (d of the first bit, p of the first bit) and the Q pair is (d of the second bit, q of the second bit).
- R8: With swap_mode at 1, the I pair is (p of the first bit, d of the first bit) and the Q pair is (q of the second bit, d of the second bit). swap_mode is sampled only when the second bit is accepted and governs both axes of that symbol.
- R9: Cycles with in_valid low do not advance the pair phase and produce no symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input bit position offered |
| in_ready | output | 1 | Mapper can take a bit this cycle |
| in_d | input | 1 | Systematic bit |
| in_p | input | 1 | Parity bit from the first constituent encoder |
| in_q | input | 1 | Parity bit from the second constituent encoder |
| swap_mode | input | 1 | 1 places parity on the protected position |
| out_valid | output | 1 | One-cycle symbol strobe |
| out_i | output | 3 | In-phase level, two's complement |
| out_q | output | 3 | Quadrature level, two's complement |

## Verification
Two events can land on one clock edge. The first is a change of swap_mode, which the bench provokes by holding the mode opposite on the first bit and flipping it on the very cycle the second bit is accepted. The expected levels for both axes then follow the mode seen at completion. The second is an offer of junk data during the output cycle, in which the strobe and the withdrawn in_ready coincide. It is judged by checking that the following pair still maps exactly as computed, with the phase unshifted. The sweep covers all sixty-four combinations of the six input bits of a pair under both modes, with idle gaps between the two halves.

// File: rtl/qmap_pkg.sv
package qmap_pkg;
  // Bit pair presented to one 4-level axis: msb is the protected sign bit.
  typedef struct packed {
    logic msb;
    logic lsb;
  } axis_pair_t;

  localparam int unsigned AXES = 2;
endpackage

// File: rtl/qmap_pair_collect.sv
// Tracks odd/even position and holds the first bit's kept fields.
module qmap_pair_collect (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic in_d,
  input  logic in_p,
  output logic second_take,
  output logic held_d,
  output logic held_p
);
  logic odd_done;

  assign second_take = take & odd_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      odd_done <= 1'b0;
      held_d   <= 1'b0;
      held_p   <= 1'b0;
    end else if (take) begin
      odd_done <= ~odd_done;
      if (!odd_done) begin
        held_d <= in_d;
        held_p <= in_p;
      end
    end
  end
endmodule

// File: rtl/qmap_axis_level.sv
// Gray 4-level map: sign from msb, magnitude 3 when lsb is set, else 1.
module qmap_axis_level #(
  parameter int unsigned LVL_W = 3
) (
  input  qmap_pkg::axis_pair_t pair,
  output logic [LVL_W-1:0]     level
);
  localparam logic [LVL_W-1:0] POS_ONE   = LVL_W'(1);
  localparam logic [LVL_W-1:0] POS_THREE = LVL_W'(3);

  logic [LVL_W-1:0] mag;

  always_comb begin
    mag   = pair.lsb ? POS_THREE : POS_ONE;
    level = pair.msb ? mag : (~mag + POS_ONE);
  end
endmodule

// File: rtl/qam16_iq_mapper.sv
module qam16_iq_mapper #(
  parameter int unsigned LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_d,
  input  logic             in_p,
  input  logic             in_q,
  input  logic             swap_mode,
  output logic             out_valid,
  output logic [LVL_W-1:0] out_i,
  output logic [LVL_W-1:0] out_q
);
  import qmap_pkg::*;

  logic take, second_take, held_d, held_p;
  axis_pair_t       pairs  [AXES];
  logic [LVL_W-1:0] levels [AXES];

  assign in_ready = ~out_valid;
  assign take     = in_valid & in_ready;

  qmap_pair_collect u_collect (
    .clk         (clk),
    .rst         (rst),
    .take        (take),
    .in_d        (in_d),
    .in_p        (in_p),
    .second_take (second_take),
    .held_d      (held_d),
    .held_p      (held_p)
  );

  // Axis 0 is in-phase (first bit, kept p); axis 1 is quadrature (second bit, kept q).
  always_comb begin
    pairs[0] = swap_mode ? '{msb: held_p, lsb: held_d} : '{msb: held_d, lsb: held_p};
    pairs[1] = swap_mode ? '{msb: in_q,   lsb: in_d}   : '{msb: in_d,   lsb: in_q};
  end

  for (genvar ax = 0; ax < AXES; ax++) begin : g_axis
    qmap_axis_level #(.LVL_W(LVL_W)) u_level (
      .pair  (pairs[ax]),
      .level (levels[ax])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= second_take;
      if (second_take) begin
        out_i <= levels[0];
        out_q <= levels[1];
      end
    end
  end
endmodule

// File: rtl/qam16_iq_mapper_chk.sv
module qam16_iq_mapper_chk #(
  parameter int unsigned LVL_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic [LVL_W-1:0] out_i,
  input logic [LVL_W-1:0] out_q
);
  logic ph;
  logic acc;
  assign acc = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst) ph <= 1'b0;
    else if (acc) ph <= ~ph;
  end

  // R4: strobe lasts one cycle
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R4, R9: strobe follows exactly the second accepted bit
  a_r4_after_pair: assert property (@(posedge clk) disable iff (rst)
    (acc && ph) |=> out_valid);

  a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !(acc && ph) |=> !out_valid);

  // R5: no acceptance while the symbol is presented
  a_r5_ready_low: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  // R6: every presented level is odd
  a_r6_odd_level: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_i[0] && out_q[0]));
endmodule

bind qam16_iq_mapper qam16_iq_mapper_chk #(.LVL_W(LVL_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_i     (out_i),
  .out_q     (out_q)
);

// File: tb/tb_qam16_iq_mapper.sv
module tb_qam16_iq_mapper;
  logic clk = 1'b0;
  logic rst, in_valid, in_d, in_p, in_q, swap_mode;
  logic in_ready, out_valid;
  logic [2:0] out_i, out_q;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  qam16_iq_mapper dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_d(in_d), .in_p(in_p), .in_q(in_q), .swap_mode(swap_mode),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  function automatic logic [2:0] lvl(input logic m, input logic l);
    if (m) return l ? 3'b011 : 3'b001;
    else   return l ? 3'b101 : 3'b111;
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Offers one bit; returns just after the accepting edge.
  task automatic offer(input logic d, input logic p, input logic q, input logic sw);
    @(negedge clk);
    in_valid = 1'b1; in_d = d; in_p = p; in_q = q; swap_mode = sw;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic run_pair(input logic [5:0] v, input logic sw1, input logic sw2,
                          input int gap, input logic junk);
    logic d1, p1, q1, d2, p2, q2;
    logic [2:0] ei, eq;
    {d1, p1, q1, d2, p2, q2} = v;
    offer(d1, p1, q1, sw1);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      in_valid = 1'b0; in_d = ~d1; in_p = ~p1; in_q = ~q1; swap_mode = ~sw1;
      check("R9 idle no strobe", {2'b0, out_valid}, 3'b000);
    end
    offer(d2, p2, q2, sw2);
    if (sw2) begin ei = lvl(p1, d1); eq = lvl(q2, d2); end
    else     begin ei = lvl(d1, p1); eq = lvl(d2, q2); end
    @(negedge clk);
    in_valid = junk; in_d = ~d2; in_p = ~p2; in_q = ~q2;
    check("R4 strobe after pair", {2'b0, out_valid}, 3'b001);
    check("R5 ready low on strobe", {2'b0, in_ready}, 3'b000);
    check(sw2 ? "R8 I swap" : "R7 I normal R6 R2", out_i, ei);
    check(sw2 ? "R8 Q swap" : "R7 Q normal R6 R3", out_q, eq);
    @(negedge clk);
    in_valid = 1'b0;
    check("R4 single pulse", {2'b0, out_valid}, 3'b000);
    check("R5 ready back", {2'b0, in_ready}, 3'b001);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected<=100000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_d = 0; in_p = 0; in_q = 0; swap_mode = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset valid", {2'b0, out_valid}, 3'b000);
    check("R1 reset ready", {2'b0, in_ready}, 3'b001);

    // R6 explicit level table via I axis, normal mode: pairs 01,00,10,11
    run_pair(6'b010_000, 1'b0, 1'b0, 0, 1'b0);
    check("R6 01 -> -3", out_i, 3'b101);
    run_pair(6'b000_000, 1'b0, 1'b0, 0, 1'b0);
    check("R6 00 -> -1", out_i, 3'b111);
    run_pair(6'b100_000, 1'b0, 1'b0, 0, 1'b0);
    check("R6 10 -> +1", out_i, 3'b001);
    run_pair(6'b110_000, 1'b0, 1'b0, 0, 1'b0);
    check("R6 11 -> +3", out_i, 3'b011);

    // Sweep of all six-bit pair contents under both modes
    for (int s = 0; s < 2; s++) begin
      for (int v = 0; v < 64; v++) begin
        run_pair(6'(v), s[0], s[0], v % 3, v[0]);
      end
    end

    // R8: mode flips on the completing bit; value at completion governs
    run_pair(6'b101_110, 1'b1, 1'b0, 1, 1'b1);
    run_pair(6'b101_110, 1'b0, 1'b1, 0, 1'b1);

    // R1: reset mid-pair restarts at the odd position
    offer(1'b1, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    run_pair(6'b011_100, 1'b0, 1'b0, 0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule